// File: doc/BRIEF.md
# Configurable SPI Serial Port

This block is a byte-wide synchronous serial port that acts as either the clock-driving master or the clock-following slave of an SPI link. An 8-bit control register sets its behaviour. The register holds a port enable, the serial clock idle level, two sticky error flags and a 4-bit mode field. Writing the data buffer starts a transfer. Reading it collects the byte that was shifted in.

In master mode, a divider produces the serial clock. The divider takes its pace either from the system clock or from an external timer tick. In slave mode, the serial clock and an active-low select arrive from outside. They pass through a synchronizer before their edges are detected. Data moves MSB first. The outgoing bit changes on the clock edge that leaves the idle level, and the incoming bit is sampled on the edge that returns to it.

The control state machine has five states:
- `ST_OFF`: port disabled or reserved mode.
- `ST_IDLE`: master waiting for a buffer write.
- `ST_LEAVE`: master half-period before the clock leaves idle.
- `ST_RETURN`: master half-period before it returns.
- `ST_SLAVE`: following the external clock.

The transitions are:
- OFF to IDLE when a master mode is enabled, and OFF to SLAVE when a slave mode is enabled.
- IDLE to LEAVE on a buffer write.
- LEAVE to RETURN on a half-period tick.
- RETURN to LEAVE on a tick, or RETURN to IDLE on the tick that completes the eighth bit.
- Any state to OFF when its mode stops applying.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, the buffer-full output is 0 and both output enables are 0. Control layout: bit 7 enable, bit 6 clock idle level, bit 5 write-collision flag, bit 4 receive-overflow flag, bits 3:0 mode.
- R2: With enable 0, or with a reserved mode (0110 to 1111) while enabled, the clock and data output enables stay 0, a buffer write starts no transfer, and buffer-full stays 0.
- R3: In master modes 0000, 0001 and 0010, the serial clock toggles every 2, 8 and 32 system clocks respectively (clock = system clock / 4, /16, /64).
- R4: In master mode 0011, the serial clock toggles once per external timer tick (clock = tick rate / 2).
- R5: While no transfer is running, the master serial clock rests at the level of control bit 6.
- R6: Data is shifted MSB first. The data output changes on the clock edge leaving the idle level, and data input is sampled on the edge returning to it.
- R7: When a transfer completes, the received byte appears on the buffer read port and buffer-full rises. A buffer read clears buffer-full.
- R8: A buffer write while a byte is being shifted sets the write-collision flag and leaves the byte being shifted unchanged.
- R9: Both error flags stay set until software writes 0 to them through the control register.
- R10: In master mode the overflow flag is never set. A completed byte always replaces the buffer, even if it is unread.
- R11: In slave mode, a byte that completes while buffer-full is 1 sets the overflow flag and is discarded, and the buffer keeps the old byte.
- R12: In slave mode 0100, a high select clears the bit counter and releases the data output (enable 0).
- R13: In slave mode 0101, the select input is ignored. The data output stays enabled and transfers proceed with select high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register contents including flags |
| buf_wr | input | 1 | Data buffer write strobe (starts a transfer) |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Data buffer read strobe (clears buffer-full) |
| buf_rdata | output | 8 | Last received byte |
| buf_full | output | 1 | A received byte is waiting to be read |
| timer_tick | input | 1 | External timer pulse for master mode 0011 |
| sck_o | output | 1 | Serial clock driven in master mode |
| sck_oe | output | 1 | Serial clock output enable |
| sck_i | input | 1 | Serial clock received in slave mode |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Serial data output enable |
| sdi_i | input | 1 | Serial data in |
| sel_n_i | input | 1 | Active-low slave select |

## Verification
The hardest situation to reach is slave overflow. It needs two complete slave bytes clocked in with no buffer read between them, and each byte must go through the synchronizer at a pace the port can follow. The bench drives the external clock slowly from a task, withholds the read after the first byte, and then checks three things: the flag, that the buffer still holds the first byte, and that the second byte never reaches it. A write collision is the other timing-bound case. The bench waits in the master shift loop for the third clock toggle and inserts a buffer write there. It then confirms that the byte seen on the data output is still the original.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;

    typedef enum logic [2:0] {
        ST_OFF,
        ST_IDLE,
        ST_LEAVE,
        ST_RETURN,
        ST_SLAVE
    } port_state_e;

    localparam logic [3:0] MODE_MST_FAST = 4'b0000;
    localparam logic [3:0] MODE_MST_MID  = 4'b0001;
    localparam logic [3:0] MODE_MST_SLOW = 4'b0010;
    localparam logic [3:0] MODE_MST_TMR  = 4'b0011;
    localparam logic [3:0] MODE_SLV_SEL  = 4'b0100;
    localparam logic [3:0] MODE_SLV_FREE = 4'b0101;

    localparam int CTL_EN   = 7;
    localparam int CTL_CKP  = 6;
    localparam int CTL_WCOL = 5;
    localparam int CTL_OVF  = 4;

endpackage

// File: rtl/spi_port_clkdiv.sv
module spi_port_clkdiv #(
    parameter int DIV_FAST = 4,
    parameter int DIV_MID  = 16,
    parameter int DIV_SLOW = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       run,
    input  logic [1:0] rate_sel,
    input  logic       timer_tick,
    output logic       half_tick
);
    localparam int HALF_FAST = DIV_FAST / 2;
    localparam int HALF_MID  = DIV_MID / 2;
    localparam int HALF_SLOW = DIV_SLOW / 2;
    localparam int CW        = (HALF_SLOW > 1) ? $clog2(HALF_SLOW) : 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] lim;

    always_comb begin
        unique case (rate_sel)
            2'd0:    lim = CW'(HALF_FAST - 1);
            2'd1:    lim = CW'(HALF_MID - 1);
            default: lim = CW'(HALF_SLOW - 1);
        endcase
    end

    assign half_tick = run && ((rate_sel == 2'd3) ? timer_tick : (cnt == lim));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 cnt <= '0;
        else if (!run || half_tick) cnt <= '0;
        else                        cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sck_i,
    input  logic sel_n_i,
    input  logic ckp,
    output logic sel_sync,
    output logic leave_pulse,
    output logic return_pulse
);
    logic [STAGES-1:0] sck_pipe;
    logic [STAGES-1:0] sel_pipe;
    logic              sck_prev;
    logic              sck_now;

    assign sck_now  = sck_pipe[STAGES-1];
    assign sel_sync = sel_pipe[STAGES-1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_pipe <= '0;
            sel_pipe <= '1;
            sck_prev <= 1'b0;
        end else begin
            sck_pipe <= {sck_pipe[STAGES-2:0], sck_i};
            sel_pipe <= {sel_pipe[STAGES-2:0], sel_n_i};
            sck_prev <= sck_now;
        end
    end

    assign leave_pulse  = (sck_now != sck_prev) && (sck_prev == ckp);
    assign return_pulse = (sck_now != sck_prev) && (sck_now == ckp);
endmodule

// File: rtl/spi_port.sv
module spi_port
    import spi_port_pkg::*;
#(
    parameter int DIV_FAST    = 4,
    parameter int DIV_MID     = 16,
    parameter int DIV_SLOW    = 64,
    parameter int SYNC_STAGES = 2,
    parameter int DW          = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ctl_wr,
    input  logic [7:0]    ctl_wdata,
    output logic [7:0]    ctl_rdata,
    input  logic          buf_wr,
    input  logic [DW-1:0] buf_wdata,
    input  logic          buf_rd,
    output logic [DW-1:0] buf_rdata,
    output logic          buf_full,
    input  logic          timer_tick,
    output logic          sck_o,
    output logic          sck_oe,
    input  logic          sck_i,
    output logic          sdo_o,
    output logic          sdo_oe,
    input  logic          sdi_i,
    input  logic          sel_n_i
);
    localparam int BW = $clog2(DW);
    localparam logic [BW-1:0] LAST_BIT = BW'(DW - 1);

    logic en, ckp, wcol, ovf;
    logic [3:0] mode;
    port_state_e st, st_nx;

    logic [DW-1:0] shreg, rxbuf;
    logic [BW-1:0] bitcnt;
    logic sck_q, sdo_q, full_q;
    logic half_tick, sel_sync, slv_leave, slv_return;
    logic is_master, is_slave, honour, xfer_busy, sel_hold;
    logic leave_ev, ret_ev, done, load, collide, ovf_set;

    assign is_master = en && (mode[3:2] == 2'b00);
    assign is_slave  = en && (mode == MODE_SLV_SEL || mode == MODE_SLV_FREE);
    assign honour    = is_slave && (mode == MODE_SLV_SEL);
    assign sel_hold  = honour && sel_sync;

    assign xfer_busy = (st == ST_LEAVE) || (st == ST_RETURN) ||
                       ((st == ST_SLAVE) && (bitcnt != '0));
    assign leave_ev  = ((st == ST_LEAVE) && half_tick) ||
                       ((st == ST_SLAVE) && slv_leave && !sel_hold);
    assign ret_ev    = ((st == ST_RETURN) && half_tick) ||
                       ((st == ST_SLAVE) && slv_return && !sel_hold);
    assign done      = ret_ev && (bitcnt == LAST_BIT);
    assign load      = buf_wr && !xfer_busy && ((st == ST_IDLE) || (st == ST_SLAVE));
    assign collide   = buf_wr && xfer_busy;
    assign ovf_set   = done && (st == ST_SLAVE) && full_q && !buf_rd;

    spi_port_clkdiv #(
        .DIV_FAST(DIV_FAST), .DIV_MID(DIV_MID), .DIV_SLOW(DIV_SLOW)
    ) u_div (
        .clk(clk), .rst_n(rst_n),
        .run((st == ST_LEAVE) || (st == ST_RETURN)),
        .rate_sel(mode[1:0]), .timer_tick(timer_tick),
        .half_tick(half_tick)
    );

    spi_port_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .sck_i(sck_i), .sel_n_i(sel_n_i), .ckp(ckp),
        .sel_sync(sel_sync), .leave_pulse(slv_leave), .return_pulse(slv_return)
    );

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_OFF:    if (is_master)      st_nx = ST_IDLE;
                       else if (is_slave)  st_nx = ST_SLAVE;
            ST_IDLE:   if (!is_master)     st_nx = ST_OFF;
                       else if (load)      st_nx = ST_LEAVE;
            ST_LEAVE:  if (!is_master)     st_nx = ST_OFF;
                       else if (half_tick) st_nx = ST_RETURN;
            ST_RETURN: if (!is_master)     st_nx = ST_OFF;
                       else if (half_tick) st_nx = (bitcnt == LAST_BIT) ? ST_IDLE : ST_LEAVE;
            ST_SLAVE:  if (!is_slave)      st_nx = ST_OFF;
            default:                       st_nx = ST_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_OFF;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            {en, ckp, wcol, ovf, mode} <= 8'h00;
            shreg  <= '0;
            rxbuf  <= '0;
            bitcnt <= '0;
            sck_q  <= 1'b0;
            sdo_q  <= 1'b0;
            full_q <= 1'b0;
        end else begin
            if (ctl_wr) {en, ckp, wcol, ovf, mode} <= ctl_wdata;
            if (collide) wcol <= 1'b1;
            if (ovf_set) ovf  <= 1'b1;

            sck_q <= (st_nx == ST_RETURN) ? ~ckp : ckp;
            if (leave_ev) sdo_q <= shreg[DW-1];

            if (load)        shreg <= buf_wdata;
            else if (ret_ev) shreg <= {shreg[DW-2:0], sdi_i};

            if (st == ST_OFF || sel_hold) bitcnt <= '0;
            else if (ret_ev)              bitcnt <= bitcnt + 1'b1;

            if (done && !ovf_set) begin
                rxbuf  <= {shreg[DW-2:0], sdi_i};
                full_q <= 1'b1;
            end else if (buf_rd) begin
                full_q <= 1'b0;
            end
        end
    end

    assign ctl_rdata = {en, ckp, wcol, ovf, mode};
    assign buf_rdata = rxbuf;
    assign buf_full  = full_q;
    assign sck_o     = sck_q;
    assign sck_oe    = is_master;
    assign sdo_o     = sdo_q;
    assign sdo_oe    = is_master || (is_slave && !(honour && sel_n_i));
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       ctl_wr,
    input logic [7:0] ctl_rdata,
    input logic       buf_wr,
    input logic       xfer_busy,
    input logic       sck_o,
    input logic       sck_oe,
    input logic       sdo_oe,
    input logic       sel_n_i
);
    logic en_b, ckp_b, wcol_b, ovf_b, master_b;
    logic [3:0] mode_b;
    assign {en_b, ckp_b, wcol_b, ovf_b, mode_b} = ctl_rdata;
    assign master_b = en_b && (mode_b[3:2] == 2'b00);

    AST_PORT_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        !en_b |-> (!sck_oe && !sdo_oe)); // R2
    AST_IDLE_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (sck_oe && !xfer_busy && $stable(ckp_b)) |-> (sck_o == ckp_b)); // R5
    AST_WCOL_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && xfer_busy && !ctl_wr) |=> wcol_b); // R8
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_b && !ctl_wr) |=> ovf_b); // R9
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (master_b && !ovf_b && !ctl_wr) |=> !ovf_b); // R10
    AST_SEL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (en_b && mode_b == 4'b0100 && sel_n_i) |-> !sdo_oe); // R12
endmodule

bind spi_port spi_port_chk u_chk (
    .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_rdata(ctl_rdata),
    .buf_wr(buf_wr), .xfer_busy(xfer_busy), .sck_o(sck_o), .sck_oe(sck_oe),
    .sdo_oe(sdo_oe), .sel_n_i(sel_n_i)
);

// File: tb/tb_spi_port.sv
`timescale 1ns/1ps
module tb_spi_port;
    logic clk = 1'b0, rst_n = 1'b0;
    logic ctl_wr = 0, buf_wr = 0, buf_rd = 0, timer_tick = 0;
    logic [7:0] ctl_wdata = 0, buf_wdata = 0;
    logic sck_i = 0, sdi_i = 0, sel_n_i = 1;
    logic [7:0] ctl_rdata, buf_rdata;
    logic buf_full, sck_o, sck_oe, sdo_o, sdo_oe;
    int errors = 0, checks = 0;
    logic ckp_cur = 0;

    always #4 clk = ~clk;

    spi_port dut (
        .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .buf_wr(buf_wr), .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
        .buf_full(buf_full), .timer_tick(timer_tick), .sck_o(sck_o), .sck_oe(sck_oe),
        .sck_i(sck_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe), .sdi_i(sdi_i), .sel_n_i(sel_n_i)
    );

    initial begin
        int t = 0;
        forever begin
            @(negedge clk);
            t++;
            timer_tick = (t % 3 == 0);
        end
    end

    function automatic int exp_half(input logic [3:0] m);
        case (m)
            4'd0: return 2;
            4'd1: return 8;
            4'd2: return 32;
            default: return 3;
        endcase
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic ctl_write(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0;
        ckp_cur = v[6];
        repeat (2) @(negedge clk);
    endtask

    task automatic buf_write(input logic [7:0] v);
        @(negedge clk); buf_wr = 1; buf_wdata = v;
        @(negedge clk); buf_wr = 0;
    endtask

    task automatic buf_read(output logic [7:0] v);
        @(negedge clk); v = buf_rdata; buf_rd = 1;
        @(negedge clk); buf_rd = 0;
    endtask

    task automatic master_xfer(input logic [7:0] tx, input logic [7:0] rxb, input bit collide,
                               output logic [7:0] got, output int gmin, output int gmax);
        logic prev;
        int tog, k, since, bi;
        buf_write(tx);
        prev = sck_o; tog = 0; k = 0; since = 0; bi = 0; gmin = 100000; gmax = 0; got = 0;
        while (tog < 16 && k < 5000) begin
            @(negedge clk);
            buf_wr = 0; k++; since++;
            if (sck_o != prev) begin
                prev = sck_o;
                if (tog > 0) begin
                    if (since < gmin) gmin = since;
                    if (since > gmax) gmax = since;
                end
                since = 0;
                if (sck_o != ckp_cur) begin
                    got = {got[6:0], sdo_o};
                    sdi_i = rxb[7-bi];
                    bi++;
                end
                tog++;
                if (collide && tog == 3) begin buf_wdata = ~tx; buf_wr = 1; end
            end
        end
        repeat (3) @(negedge clk);
    endtask

    task automatic slave_bits(input logic [7:0] rxb, input int n, output logic [7:0] got);
        got = 0;
        for (int i = 0; i < n; i++) begin
            sck_i = ~ckp_cur; sdi_i = rxb[7-i];
            repeat (8) @(negedge clk);
            got = {got[6:0], sdo_o};
            sck_i = ckp_cur;
            repeat (8) @(negedge clk);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] tx, rx, got, rd;
        logic [3:0] m;
        int gmin, gmax, toggles;
        logic prev;
        void'($urandom(32'd17));
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk);
        chk(ctl_rdata == 8'h00, "R1 control reset", ctl_rdata, 0);
        chk(!buf_full && !sck_oe && !sdo_oe, "R1 outputs reset", {buf_full, sck_oe, sdo_oe}, 0);

        // R2: disabled port and reserved mode
        for (int p = 0; p < 2; p++) begin
            ctl_write(p == 0 ? 8'h00 : 8'h89);
            buf_write(8'h5A);
            prev = sck_o; toggles = 0;
            for (int i = 0; i < 100; i++) begin
                @(negedge clk);
                if (sck_o != prev || sck_oe || sdo_oe) toggles++;
                prev = sck_o;
            end
            chk(toggles == 0 && !buf_full, "R2 no activity", toggles, 0);
        end

        // R5: idle level follows polarity bit
        ctl_write(8'hC0);
        chk(sck_o == 1'b1, "R5 idle high", sck_o, 1);
        ctl_write(8'h80);
        chk(sck_o == 1'b0, "R5 idle low", sck_o, 0);

        // R3 R4 R6 R7: random master transfers
        for (int it = 0; it < 12; it++) begin
            m = 4'($urandom() % 4);
            if (it < 4) m = 4'(it);
            ckp_cur = 1'($urandom());
            tx = 8'($urandom()); rx = 8'($urandom());
            ctl_write({1'b1, ckp_cur, 2'b00, m});
            master_xfer(tx, rx, 1'b0, got, gmin, gmax);
            chk(gmin == exp_half(m) && gmax == exp_half(m), (m == 3) ? "R4 tick pace" : "R3 divider pace",
                gmax, exp_half(m));
            chk(got == tx, "R6 MSB-first output", got, tx);
            chk(buf_full && buf_rdata == rx, "R7 received byte", buf_rdata, rx);
            buf_read(rd);
            @(negedge clk);
            chk(!buf_full, "R7 read clears full", buf_full, 0);
        end

        // R10: master leaves buffer unread, no overflow, buffer replaced
        ctl_write(8'h80);
        master_xfer(8'h12, 8'h34, 1'b0, got, gmin, gmax);
        master_xfer(8'h56, 8'h78, 1'b0, got, gmin, gmax);
        chk(ctl_rdata[4] == 1'b0, "R10 no master overflow", ctl_rdata, 8'h80);
        chk(buf_rdata == 8'h78, "R10 buffer replaced", buf_rdata, 8'h78);
        buf_read(rd);

        // R8: collision mid-transfer
        ctl_write(8'h82);
        master_xfer(8'hC5, 8'h3A, 1'b1, got, gmin, gmax);
        chk(ctl_rdata[5] == 1'b1, "R8 collision flag", ctl_rdata, 8'hA2);
        chk(got == 8'hC5, "R8 shifted byte unchanged", got, 8'hC5);
        buf_read(rd);
        repeat (20) @(negedge clk);
        chk(ctl_rdata[5] == 1'b1, "R9 wcol sticky", ctl_rdata, 8'hA2);
        ctl_write(8'h82);
        chk(ctl_rdata[5] == 1'b0, "R9 wcol cleared", ctl_rdata, 8'h82);

        // R11: slave overflow
        sel_n_i = 0; ckp_cur = 0; sck_i = 0;
        ctl_write(8'h84);
        buf_write(8'h96);
        slave_bits(8'hC3, 8, got);
        chk(got == 8'h96 && buf_full && buf_rdata == 8'hC3, "R11 first slave byte", buf_rdata, 8'hC3);
        slave_bits(8'h77, 8, got);
        chk(ctl_rdata[4] == 1'b1, "R11 overflow set", ctl_rdata, 8'h94);
        buf_read(rd);
        chk(rd == 8'hC3, "R11 new byte discarded", rd, 8'hC3);
        repeat (10) @(negedge clk);
        chk(ctl_rdata[4] == 1'b1, "R9 ovf sticky", ctl_rdata, 8'h94);
        ctl_write(8'h84);
        chk(ctl_rdata[4] == 1'b0, "R9 ovf cleared", ctl_rdata, 8'h84);

        // R12: select high resets count and releases output
        ckp_cur = 1; sck_i = 1;
        repeat (4) @(negedge clk);
        ctl_write(8'hC4);
        buf_write(8'h3C);
        slave_bits(8'hFF, 3, got);
        sel_n_i = 1;
        repeat (8) @(negedge clk);
        chk(sdo_oe == 1'b0, "R12 output released", sdo_oe, 0);
        sel_n_i = 0;
        repeat (8) @(negedge clk);
        buf_write(8'hA5);
        slave_bits(8'h5A, 8, got);
        chk(got == 8'hA5 && buf_rdata == 8'h5A, "R12 count restarted", buf_rdata, 8'h5A);
        buf_read(rd);

        // R13: select ignored
        ctl_write(8'hC5);
        sel_n_i = 1;
        repeat (8) @(negedge clk);
        chk(sdo_oe == 1'b1, "R13 output enabled", sdo_oe, 1);
        buf_write(8'h81);
        slave_bits(8'h42, 8, got);
        chk(got == 8'h81 && buf_full && buf_rdata == 8'h42, "R13 transfer with select high", buf_rdata, 8'h42);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule